// File: doc/BRIEF.md
# Configurable GPIO Port Controller

An eight-pin general-purpose I/O port for a small microcontroller. Three configuration bits per pin (direction, option and data) jointly pick one of eight pin modes: three digital input flavours (with pull-up, floating, with pull-up and interrupt), an analog input, and open-drain or push-pull output driving either level. The block turns each pin's triple into pad controls (output enable, output value, pull-up enable, analog select) and takes in pad levels that are already synchronized to its clock.

Software reaches the configuration through a four-location register interface. In the input modes the data bit is part of the configuration and holds no output value. A read of the data location therefore returns the live pad level for input pins and the stored bit only for output pins. Falling edges on pins in the interrupt mode raise one sticky pending flag, provided the global enable is set. That flag is the interrupt request and also the wake request that ends the wait and stop low-power states.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction, option and data registers, the global enable and the pending flag are all 0, so every pin is an input with pull-up: `pad_pu_o` is all ones, `pad_oe_o`, `pad_out_o`, `pad_ana_o`, `irq_o` and `wake_o` are 0.
- R2: A pin with {dir,opt,dat} = 001 is a floating input: pull-up, output enable, output value and analog select are all 0. The code 000 is an input with pull-up.
- R3: A pin with code 010 is an input with its pull-up on and acts as an interrupt source.
- R4: A pin with code 011 is an analog input: analog select is 1, pull-up is 0, and its bit in a data read is 0 whatever the pad level.
- R5: A pin with code 10x is open drain: output value is 0 and output enable is 1 for data 0 and 0 (floating) for data 1.
- R6: A pin with code 11x is push-pull: output enable is 1 and output value equals the data bit.
- R7: A read of address 0 (data) returns, per bit, the stored data bit when that pin's direction bit is 1, and the pad level (0 for analog pins) when it is 0.
- R8: If a pin in mode 010 sees its pad go from 1 to 0 between two clock edges while the global enable is 1, `irq_o` becomes 1 after the next clock edge and stays 1.
- R9: Falling edges on pins not in mode 010, rising edges, and any edge while the global enable is 0 leave the pending flag unchanged.
- R10: Writing address 3 with bit 1 set clears the pending flag. If a new falling edge is detected in the same cycle, the flag stays set.
- R11: `wake_o` equals `irq_o` on every cycle.
- R12: Addresses 1, 2 and 3 read back direction, option and control. Control bit 0 is the global enable (written by software), bit 1 is the pending flag, and the upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 data, 1 direction, 2 option, 3 control |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for `addr_i` |
| pad_i | input | 8 | Synchronized pad levels |
| pad_oe_o | output | 8 | Pad output enable per pin |
| pad_out_o | output | 8 | Pad output value per pin |
| pad_pu_o | output | 8 | Pull-up enable per pin |
| pad_ana_o | output | 8 | Analog select per pin |
| irq_o | output | 1 | External interrupt pending |
| wake_o | output | 1 | Wake request for the low-power states |

## Verification
The checker watches every cycle for the properties that hold everywhere. Analog select and pull-up are never both on. No pin is driven unless its direction bit is 1. A driven high level appears only on push-pull pins. The pending flag rises only while the enable is set and drops only on a clear write. Wake always follows the interrupt. The exact decoding of each mode, the pin-level data read, set-over-clear in the same cycle, and the rejection of edges on the wrong mode or with the enable off only show up in the bench's directed sequences and its random traffic against a cycle model.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  // pin mode code = {dir, opt, dat}
  typedef enum logic [2:0] {
    M_IN_PU    = 3'b000,
    M_IN_FLOAT = 3'b001,
    M_IN_IRQ   = 3'b010,
    M_IN_ANA   = 3'b011,
    M_OD_LO    = 3'b100,
    M_OD_HI    = 3'b101,
    M_PP_LO    = 3'b110,
    M_PP_HI    = 3'b111
  } pin_mode_e;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_DIR  = 2'd1;
  localparam logic [1:0] A_OPT  = 2'd2;
  localparam logic [1:0] A_CTRL = 2'd3;

  localparam int CTRL_GEN_BIT  = 0;
  localparam int CTRL_PEND_BIT = 1;
endpackage

// File: rtl/gpio_pin_cfg.sv
module gpio_pin_cfg
  import gpio_port_pkg::*;
(
  input  logic dir_i,
  input  logic opt_i,
  input  logic dat_i,
  input  logic pad_i,
  output logic oe_o,
  output logic out_o,
  output logic pu_o,
  output logic ana_o,
  output logic din_o,
  output logic irq_sel_o
);
  pin_mode_e mode;
  assign mode = pin_mode_e'({dir_i, opt_i, dat_i});

  always_comb begin
    oe_o      = 1'b0;
    out_o     = 1'b0;
    pu_o      = 1'b0;
    ana_o     = 1'b0;
    irq_sel_o = 1'b0;
    case (mode)
      M_IN_PU:    pu_o = 1'b1;
      M_IN_FLOAT: ;
      M_IN_IRQ: begin
        pu_o      = 1'b1;
        irq_sel_o = 1'b1;
      end
      M_IN_ANA:   ana_o = 1'b1;
      M_OD_LO:    oe_o = 1'b1;      // pull low
      M_OD_HI:    ;                 // released, pin floats
      M_PP_LO:    oe_o = 1'b1;
      M_PP_HI: begin
        oe_o  = 1'b1;
        out_o = 1'b1;
      end
      default: ;
    endcase
  end

  // digital input path is gated off in analog mode
  assign din_o = pad_i & ~ana_o;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] dat_q_o,
  output logic [WIDTH-1:0] dir_q_o,
  output logic [WIDTH-1:0] opt_q_o,
  output logic             gen_q_o,
  output logic             pend_clr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dat_q_o <= '0;
      dir_q_o <= '0;
      opt_q_o <= '0;
      gen_q_o <= 1'b0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_DATA: dat_q_o <= wdata_i;
        A_DIR:  dir_q_o <= wdata_i;
        A_OPT:  opt_q_o <= wdata_i;
        A_CTRL: gen_q_o <= wdata_i[CTRL_GEN_BIT];
        default: ;
      endcase
    end
  end

  assign pend_clr_o = wr_en_i && (addr_i == A_CTRL) && wdata_i[CTRL_PEND_BIT];
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pad_i,
  input  logic [WIDTH-1:0] sel_i,
  input  logic             gen_i,
  input  logic             clr_i,
  output logic             pend_o
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] fall;
  logic             hit;

  assign fall = prev_q & ~pad_i & sel_i;
  assign hit  = (|fall) & gen_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '1;
      pend_o <= 1'b0;
    end else begin
      prev_q <= pad_i;
      if (hit)        pend_o <= 1'b1;   // set wins over clear
      else if (clr_i) pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  input  logic [WIDTH-1:0] pad_i,
  output logic [WIDTH-1:0] pad_oe_o,
  output logic [WIDTH-1:0] pad_out_o,
  output logic [WIDTH-1:0] pad_pu_o,
  output logic [WIDTH-1:0] pad_ana_o,
  output logic             irq_o,
  output logic             wake_o
);
  localparam int CTRL_PAD = WIDTH - 2;

  logic [WIDTH-1:0] dat_q, dir_q, opt_q;
  logic [WIDTH-1:0] din, irq_sel, dat_rd;
  logic             gen_q, pend_clr, pend;

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .dat_q_o    (dat_q),
    .dir_q_o    (dir_q),
    .opt_q_o    (opt_q),
    .gen_q_o    (gen_q),
    .pend_clr_o (pend_clr)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    gpio_pin_cfg u_cfg (
      .dir_i     (dir_q[i]),
      .opt_i     (opt_q[i]),
      .dat_i     (dat_q[i]),
      .pad_i     (pad_i[i]),
      .oe_o      (pad_oe_o[i]),
      .out_o     (pad_out_o[i]),
      .pu_o      (pad_pu_o[i]),
      .ana_o     (pad_ana_o[i]),
      .din_o     (din[i]),
      .irq_sel_o (irq_sel[i])
    );
    // input pins read the pad, output pins read the latch
    assign dat_rd[i] = dir_q[i] ? dat_q[i] : din[i];
  end

  gpio_irq #(.WIDTH(WIDTH)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pad_i  (pad_i),
    .sel_i  (irq_sel),
    .gen_i  (gen_q),
    .clr_i  (pend_clr),
    .pend_o (pend)
  );

  always_comb begin
    case (addr_i)
      A_DATA:  rdata_o = dat_rd;
      A_DIR:   rdata_o = dir_q;
      A_OPT:   rdata_o = opt_q;
      default: rdata_o = {{CTRL_PAD{1'b0}}, pend, gen_q};
    endcase
  end

  assign irq_o  = pend;
  assign wake_o = pend;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       addr_i,
  input logic [WIDTH-1:0] wdata_i,
  input logic [WIDTH-1:0] pad_oe_o,
  input logic [WIDTH-1:0] pad_out_o,
  input logic [WIDTH-1:0] pad_pu_o,
  input logic [WIDTH-1:0] pad_ana_o,
  input logic [WIDTH-1:0] dir_q,
  input logic [WIDTH-1:0] opt_q,
  input logic             gen_q,
  input logic             irq_o,
  input logic             wake_o
);
  // R4: analog pins never pulled up
  p_ana_no_pull_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_ana_o & pad_pu_o) == '0);

  // R5: only output-direction pins drive
  p_drive_needs_dir_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & ~dir_q) == '0);

  // R6: high level only from push-pull pins
  p_high_only_pp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_out_o & ~(dir_q & opt_q)) == '0);

  // R8: pending rises only with global enable set
  p_set_needs_gen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(gen_q));

  // R10: pending holds unless cleared
  p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(wr_en_i && addr_i == 2'd3 && wdata_i[1])) |=> irq_o);

  // R11: wake follows interrupt
  p_wake_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o == irq_o);
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .pad_oe_o  (pad_oe_o),
  .pad_out_o (pad_out_o),
  .pad_pu_o  (pad_pu_o),
  .pad_ana_o (pad_ana_o),
  .dir_q     (dir_q),
  .opt_q     (opt_q),
  .gen_q     (gen_q),
  .irq_o     (irq_o),
  .wake_o    (wake_o)
);

// File: tb/tb_gpio_port.sv
`timescale 1ns/1ps
module tb_gpio_port;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         we = 1'b0;
  logic [1:0]   addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] pad = '1;
  logic [W-1:0] rdata, oe, outv, pu, ana;
  logic         irq, wake;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model
  logic [W-1:0] m_dat = '0, m_dir = '0, m_opt = '0, m_prev = '1;
  logic         m_gen = 1'b0, m_pend = 1'b0;

  always #5 clk = ~clk;

  gpio_port #(.WIDTH(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pad_i(pad), .pad_oe_o(oe), .pad_out_o(outv),
    .pad_pu_o(pu), .pad_ana_o(ana), .irq_o(irq), .wake_o(wake)
  );

  function automatic logic [W-1:0] e_oe();   return m_dir & (m_opt | ~m_dat); endfunction
  function automatic logic [W-1:0] e_out();  return m_dir & m_opt & m_dat; endfunction
  function automatic logic [W-1:0] e_pu();   return ~m_dir & ~m_dat; endfunction
  function automatic logic [W-1:0] e_ana();  return ~m_dir & m_opt & m_dat; endfunction
  function automatic logic [W-1:0] e_sel();  return ~m_dir & m_opt & ~m_dat; endfunction
  function automatic logic [W-1:0] e_rd(input logic [1:0] a, input logic [W-1:0] p);
    case (a)
      2'd0:    return (m_dir & m_dat) | (~m_dir & p & ~e_ana());
      2'd1:    return m_dir;
      2'd2:    return m_opt;
      default: return {{(W-2){1'b0}}, m_pend, m_gen};
    endcase
  endfunction

  task automatic cmp(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    cmp("R5 R6 oe",  oe,   e_oe());
    cmp("R5 R6 out", outv, e_out());
    cmp("R2 R3 pu",  pu,   e_pu());
    cmp("R4 ana",    ana,  e_ana());
    cmp("R7 R12 rd", rdata, e_rd(addr, pad));
    cmp("R8 R9 R10 irq", {{(W-1){1'b0}}, irq},  {{(W-1){1'b0}}, m_pend});
    cmp("R11 wake",      {{(W-1){1'b0}}, wake}, {{(W-1){1'b0}}, irq});
  endtask

  task automatic step(input bit w, input logic [1:0] a, input logic [W-1:0] d,
                      input logic [W-1:0] p);
    logic hit, clr;
    @(negedge clk);
    we = w; addr = a; wdata = d; pad = p;
    #1 check_all();
    @(posedge clk);
    hit = (|(m_prev & ~p & e_sel())) & m_gen;
    clr = w && (a == 2'd3) && d[1];
    m_pend = hit | (m_pend & ~clr);
    if (w) begin
      case (a)
        2'd0: m_dat = d;
        2'd1: m_dir = d;
        2'd2: m_opt = d;
        default: m_gen = d[0];
      endcase
    end
    m_prev = p;
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d, input logic [W-1:0] p);
    step(1'b1, a, d, p);
  endtask

  task automatic idle(input logic [1:0] a, input logic [W-1:0] p);
    step(1'b0, a, '0, p);
  endtask

  initial begin
    logic [W-1:0] p;
    void'($urandom(32'd1234));
    #22 rst_n = 1'b1;
    // R1: reset state
    @(negedge clk);
    cmp("R1 pu",  pu,  '1);
    cmp("R1 oe",  oe,  '0);
    cmp("R1 ana", ana, '0);
    cmp("R1 irq", {{(W-1){1'b0}}, irq | wake}, '0);
    idle(2'd0, 8'hA5);                       // R7 reads pad
    // R2/R4/R3 inputs: pins0-1 float, 2-3 analog, 4-5 interrupt
    wr(2'd2, 8'h3C, 8'hFF);
    wr(2'd0, 8'h0F, 8'hFF);
    idle(2'd0, 8'hFF);                       // R4 analog bits read 0
    idle(2'd3, 8'hFF);
    // R9: enable off, falling edge ignored
    idle(2'd3, 8'hEF);
    idle(2'd3, 8'hFF);
    // R8: enable on, falling edge on pin 4
    wr(2'd3, 8'h01, 8'hFF);
    idle(2'd3, 8'hEF);
    idle(2'd3, 8'hEF);
    // R9: rising edge and falls on non-interrupt pins
    idle(2'd3, 8'hFF);
    wr(2'd3, 8'h03, 8'hFF);                  // R10 clear
    idle(2'd3, 8'hF0);
    idle(2'd3, 8'hFF);
    // R10: set and clear in the same cycle, set wins
    wr(2'd3, 8'h03, 8'hDF);
    idle(2'd3, 8'hDF);
    wr(2'd3, 8'h03, 8'hFF);
    // R5/R6 outputs: pins 0-3 open drain, 4-7 push-pull
    wr(2'd2, 8'hF0, 8'hFF);
    wr(2'd1, 8'hFF, 8'hFF);
    wr(2'd0, 8'h5A, 8'h00);
    idle(2'd0, 8'h00);                       // R7 latch read
    idle(2'd1, 8'h00);                       // R12
    // random traffic
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(3) == 0) p = $urandom();
      else p = pad ^ (W'(1) << $urandom_range(W-1));
      if ($urandom_range(2) == 0)
        step(1'b1, 2'($urandom_range(3)), W'($urandom()), p);
      else
        step(1'b0, 2'($urandom_range(3)), W'($urandom()), p);
    end
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule